// File: doc/BRIEF.md
# Byte-Lane Masked Synchronous SRAM with Shared Data Bus

This block is a single-port synchronous memory. It sits behind a bidirectional data bus, which is modelled here as three signals: an input word, an output word and a drive enable. The word is split into byte lanes. Each lane holds eight data bits plus one parity bit. The parity bit is stored and returned exactly as it was supplied; the block does not generate or check it.

A write is issued in one clock and its data is taken from the bus in the next clock. Only the lanes whose select bit was high with the command are updated, so a partial update needs no prior read. A read returns its word on the bus one clock after the address is sampled. The bus is driven only for a read, only while the active-low output enable is held low, and never while write data is arriving.

Commands may follow one another in every cycle. A read of the word whose write data is arriving in that same cycle returns the merged new word.

Top module: `byte_mask_sram`

## Requirements
- R1: The write data phase stores, for each lane i whose select bit was high, bus bits [9i+8:9i] (data in [9i+7:9i], parity in bit 9i+8) into that lane of the addressed word.
- R2: Lanes whose select bit was low with the write command keep both their data and parity bits.
- R3: A read command (cs=1, we=0) puts the stored word on bus_out after the next rising edge, and bus_drive is then high while oe_n is low.
- R4: While oe_n is high, bus_drive is low.
- R5: During the cycle after a write command (the write data phase), bus_drive is low whatever oe_n is.
- R6: Lane selects and address are captured with the write command; write data is taken from bus_in at the following edge; lane_sel and bus_in values in other cycles have no effect on that write.
- R7: Write commands on consecutive cycles each apply their own lane selects to their own data.
- R8: A read issued in the data phase of a write to the same address returns the word with that write's selected lanes already updated.
- R9: With cs low, no write takes place (even with we high) and bus_drive is low after the next edge.
- R10: Synchronous reset drops a pending write data phase without storing it and leaves bus_drive low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write command when high with cs, read when low |
| lane_sel | input | LANES | Per-lane write select, active high |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low |
| bus_in | input | LANES*9 | Data arriving from the shared bus |
| bus_out | output | LANES*9 | Data the block places on the shared bus |
| bus_drive | output | 1 | High when the block drives the bus |

## Verification
A read of a word can be sampled on the very edge at which the data for an earlier masked write to that same word is being stored. Thus a memory update and a memory fetch of one address fall in the same cycle. The bench sets this up by giving a write command and then, on the next cycle, a read of that address, both in directed cases and in a long random stream over a few addresses. The returned word is compared with a behavioural model that applies the pending masked write before it looks up the read. The same streams also place write data phases against a low output enable and check that the bus stays undriven.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_DATA_W = 8;
  localparam int LANE_W      = LANE_DATA_W + 1;

  typedef logic [LANE_W-1:0] lane_word_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_t;
endpackage

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_sel,
  output op_t               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  sel_q
);

  op_t op_d;

  always_comb begin
    if (!cs)     op_d = OP_NONE;
    else if (we) op_d = OP_WRITE;
    else         op_d = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) op_q <= OP_NONE;
    else     op_q <= op_d;
  end

  always_ff @(posedge clk) begin
    if (cs) begin
      addr_q <= addr;
      sel_q  <= lane_sel;
    end
  end

  // R6: selects of a write command are held for its data phase
  p_sel_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (cs && we) |=> (op_q == OP_WRITE && sel_q == $past(lane_sel)));

  // R9: an unselected cycle never yields a command
  p_idle_no_op_r9: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (op_q == OP_NONE));

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  lane_word_t        wr_word,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              fwd_en,
  output lane_word_t        rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  lane_word_t mem [DEPTH];
  lane_word_t mem_q;
  lane_word_t fwd_word_q;
  logic       fwd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q <= 1'b0;
    end else if (rd_en) begin
      fwd_q      <= fwd_en;
      fwd_word_q <= wr_word;
    end
  end

  assign rd_word = fwd_q ? fwd_word_q : mem_q;

  // R8: bypass only for a real read that collides with this lane's write
  p_fwd_pairs_r8: assert property (@(posedge clk) disable iff (rst)
    fwd_en |-> (rd_en && wr_en && rd_addr == wr_addr));

  // R10: array untouched while reset is high
  p_no_wr_in_rst_r10: assert property (@(posedge clk)
    rst |-> !wr_en);

endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  op_t                     op_q,
  input  logic                    oe_n,
  input  lane_word_t [LANES-1:0]  lane_words,
  output logic [LANES*LANE_W-1:0] bus_out,
  output logic                    bus_drive
);

  logic rd_valid;
  logic wr_phase;

  assign rd_valid  = (op_q == OP_READ);
  assign wr_phase  = (op_q == OP_WRITE);
  assign bus_drive = rd_valid && !oe_n && !wr_phase;

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign bus_out[i*LANE_W +: LANE_W] = lane_words[i];
  end

  // R5: write data phase keeps the bus free
  p_no_drive_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_phase |-> !bus_drive);

  // R4: disabled output enable releases the bus
  p_oe_release_r4: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !bus_drive);

endmodule

// File: rtl/byte_mask_sram.sv
module byte_mask_sram
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] bus_in,
  output logic [LANES*LANE_W-1:0] bus_out,
  output logic                    bus_drive
);

  op_t                    op_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [LANES-1:0]       sel_q;
  logic                   wr_phase;
  logic                   rd_now;
  logic                   collide;
  lane_word_t [LANES-1:0] lane_words;

  sram_cmd_stage #(.LANES(LANES), .ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
    .lane_sel(lane_sel), .op_q(op_q), .addr_q(addr_q), .sel_q(sel_q)
  );

  assign wr_phase = (op_q == OP_WRITE) && !rst;
  assign rd_now   = cs && !we && !rst;
  assign collide  = wr_phase && rd_now && (addr_q == addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_lane_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(wr_phase && sel_q[i]),
      .wr_addr(addr_q),
      .wr_word(bus_in[i*LANE_W +: LANE_W]),
      .rd_en(rd_now),
      .rd_addr(addr),
      .fwd_en(collide && sel_q[i]),
      .rd_word(lane_words[i])
    );
  end

  sram_bus_ctl #(.LANES(LANES)) u_bus (
    .clk(clk), .rst(rst), .op_q(op_q), .oe_n(oe_n),
    .lane_words(lane_words), .bus_out(bus_out), .bus_drive(bus_drive)
  );

  // R3: read result is on the bus exactly one edge later, gated by oe_n
  p_read_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (cs && !we) |=> (bus_drive == !oe_n));

  // R9: no drive after an unselected cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !bus_drive);

endmodule

// File: tb/test_byte_mask_sram.sv
module test_byte_mask_sram;
  localparam int CLK_P  = 10;
  localparam int LANES  = 4;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = LANES * 9;

  logic             clk = 1'b0;
  logic             rst, cs, we, oe_n;
  logic [LANES-1:0] lane_sel;
  logic [ADDR_W-1:0] addr;
  logic [BUS_W-1:0] bus_in, bus_out;
  logic             bus_drive;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [BUS_W-1:0]  ref_mem [1 << ADDR_W];
  bit                pend = 0;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_sel;
  bit                exp_valid = 0;
  logic [BUS_W-1:0]  exp_word;

  byte_mask_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) i_byte_mask_sram (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .lane_sel(lane_sel),
    .addr(addr), .oe_n(oe_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_drive(bus_drive)
  );

  initial forever #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [BUS_W-1:0] act,
                       input logic [BUS_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive inputs, update model at the edge, compare at negedge
  task automatic step(input bit r, input bit c, input bit w,
                      input logic [ADDR_W-1:0] a, input logic [LANES-1:0] s,
                      input bit oen, input logic [BUS_W-1:0] d,
                      input string req);
    rst = r; cs = c; we = w; addr = a; lane_sel = s; oe_n = oen; bus_in = d;
    @(posedge clk);
    if (r) begin
      pend = 0; exp_valid = 0;
    end else begin
      if (pend)
        for (int i = 0; i < LANES; i++)
          if (pend_sel[i]) ref_mem[pend_addr][i*9 +: 9] = d[i*9 +: 9];
      exp_valid = c && !w;
      if (exp_valid) exp_word = ref_mem[a];
      pend = c && w;
      pend_addr = a; pend_sel = s;
    end
    @(negedge clk);
    check({req, " drive"}, BUS_W'(bus_drive), BUS_W'(exp_valid && !oen));
    if (exp_valid && !oen) check({req, " data"}, bus_out, exp_word);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] s,
                    input logic [BUS_W-1:0] d, input string req);
    step(0, 1, 1, a, s, 0, '0, req);
    step(0, 0, 0, '0, '0, 0, d, req);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string req);
    step(0, 1, 0, a, '0, 0, '0, req);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; cs = 0; we = 0; addr = '0; lane_sel = '0; oe_n = 1; bus_in = '0;
    @(negedge clk);
    step(1, 0, 0, '0, '0, 0, '0, "R10 reset");
    step(1, 1, 0, '0, '0, 0, '0, "R10 reset");

    // fill working addresses with full-width words
    for (int a = 0; a < 8; a++)
      wr(ADDR_W'(a), '1, {BUS_W/4{4'(a + 4'h3)}} ^ 36'h9_A5C3_1E77, "R1 fill");
    for (int a = 0; a < 8; a++) rd(ADDR_W'(a), "R3 read");

    // partial write, parity bits included
    wr(8'd2, 4'b0101, 36'hF_FFFF_FFFF, "R1 partial");
    rd(8'd2, "R2 partial readback");
    wr(8'd3, 4'b0000, 36'h0_0000_0000, "R2 empty mask");
    rd(8'd3, "R2 empty mask readback");

    // oe_n high on a read
    step(0, 1, 0, 8'd1, '0, 1, '0, "R4 oe high");
    rd(8'd1, "R3 read after R4");

    // data phase with oe_n low: bus must stay released
    step(0, 1, 1, 8'd4, 4'b1111, 0, '0, "R5 cmd");
    step(0, 0, 0, '0, '0, 0, 36'h1_2345_6789, "R5 data phase");
    rd(8'd4, "R5 readback");

    // selects captured with command; other-cycle lanes and bus ignored
    step(0, 1, 1, 8'd5, 4'b0011, 0, 36'hA_AAAA_AAAA, "R6 cmd");
    step(0, 0, 0, '0, 4'b1100, 0, 36'h0_DEAD_BEEF, "R6 data");
    rd(8'd5, "R6 readback");

    // back-to-back writes with distinct masks
    step(0, 1, 1, 8'd6, 4'b0001, 0, '0, "R7 w0");
    step(0, 1, 1, 8'd6, 4'b1000, 0, 36'h1_1111_1111, "R7 w1");
    step(0, 1, 1, 8'd7, 4'b0110, 0, 36'h2_2222_2222, "R7 w2");
    step(0, 0, 0, '0, '0, 0, 36'h3_3333_3333, "R7 d2");
    rd(8'd6, "R7 readback");
    rd(8'd7, "R7 readback");

    // read colliding with write data phase
    step(0, 1, 1, 8'd0, 4'b1010, 0, '0, "R8 cmd");
    step(0, 1, 0, 8'd0, '0, 0, 36'h5_6789_ABCD, "R8 collide");
    rd(8'd0, "R8 readback");

    // unselected write attempt
    step(0, 0, 1, 8'd1, 4'b1111, 0, '0, "R9 idle we");
    step(0, 0, 0, '0, '0, 0, 36'h7_7777_7777, "R9 idle data");
    rd(8'd1, "R9 readback");

    // reset during data phase drops the write
    step(0, 1, 1, 8'd2, 4'b1111, 0, '0, "R10 cmd");
    step(1, 0, 0, '0, '0, 0, 36'h8_8888_8888, "R10 reset data");
    rd(8'd2, "R10 readback");

    // random stream over the filled addresses
    for (int k = 0; k < 600; k++)
      step(0, 1'($urandom), 1'($urandom), ADDR_W'($urandom_range(0, 7)),
           4'($urandom), 1'($urandom_range(0, 3) == 0),
           {4'($urandom), 32'($urandom)}, "R8 random");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule